// File: doc/BRIEF.md
# Inverter Bridge Fault Supervisor

This block sits between a motor-control PWM engine and the six gate drivers of a three-phase bridge. It decides, every clock cycle, whether each high-side and low-side switch may be driven. Its inputs are a combined over-current/over-temperature trip, an enable, a logic-supply undervoltage flag, a high-side supply undervoltage flag for each phase, and a negative switch-node transient flag for each phase. All of these arrive as digital levels. The block drives an active-low fault output and one permit per switch. The PWM engine ANDs each gate command with its permit.

Each source follows its own rule. A trip is first qualified by a stability filter. It then shuts the whole bridge and reports a fault. The fault is held by a programmable clear counter that starts only once the trip has gone away. A new trip reloads that counter. A logic-supply undervoltage also shuts the bridge and reports a fault, but it releases as soon as the flag clears. Enable low silences the bridge without reporting anything. The per-phase conditions affect only that phase's high side. A high-side supply dip disarms the phase until the PWM engine issues a fresh turn-on, which is a falling edge on the active-low high-side command. A qualified negative transient blanks that high side for a fixed hold-off. After reset the block is faulted and the bridge is off.

Top module: `bridge_fault_supervisor`

## Requirements
- R1: When the trip input has been high for FILTER_CYCLES consecutive clock samples, fault_n_o goes low and every permit goes low on that sample.
- R2: A high pulse on trip_i, or a low pulse on enable_i, that lasts fewer than FILTER_CYCLES samples changes no output at any time.
- R3: The clear counter does not run while the qualified trip is active. After trip_i has been low for FILTER_CYCLES samples, fault_n_o stays low and all permits stay low for exactly CLEAR_CYCLES further cycles, and both then release.
- R4: A qualified trip that occurs while the clear counter is running keeps the fault asserted. It restarts the full CLEAR_CYCLES interval, counted from the release of the new trip.
- R5: While logic_uv_i is high, fault_n_o is low and all permits are low in the same cycle. Both recover in the cycle after the flag clears, with no latching.
- R6: Once enable_i has been low for FILTER_CYCLES samples, all permits are low while fault_n_o stays high. Permits return FILTER_CYCLES samples after enable_i is high again.
- R7: hs_uv_i[p] high forces hs_permit_o[p] low at once. It has no effect on fault_n_o, on ls_permit_o, or on the other phases.
- R8: After hs_uv_i[p] clears, hs_permit_o[p] stays low until hs_cmd_n_i[p] is sampled 1 and then 0 on consecutive clocks while the supply flag is low. A falling edge seen while the flag is high does not arm the phase. Arming takes effect in the cycle after the 0 sample.
- R9: neg_tr_i[p] high for TRANSIENT_MIN consecutive samples forces hs_permit_o[p] low from that sample for HOLDOFF_CYCLES cycles after the last qualifying sample. A shorter pulse has no effect, and low sides are untouched.
- R10: During reset, fault_n_o is low and all permits are low. After reset is released, the fault clears after CLEAR_CYCLES cycles, or later if the logic supply is not yet good. Each high side then still needs a fresh turn-on edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trip_i | input | 1 | Over-current / over-temperature trip, active high |
| enable_i | input | 1 | Bridge enable, active high |
| logic_uv_i | input | 1 | Logic-supply undervoltage flag, active high |
| hs_uv_i | input | PHASES | Per-phase high-side supply undervoltage flag |
| neg_tr_i | input | PHASES | Per-phase negative switch-node transient flag |
| hs_cmd_n_i | input | PHASES | Per-phase high-side turn-on command, active low |
| fault_n_o | output | 1 | Fault report, low while a trip or logic undervoltage is in force |
| hs_permit_o | output | PHASES | Per-phase high-side drive permit |
| ls_permit_o | output | PHASES | Per-phase low-side drive permit |

## Verification
The assertions assume that every input is a clean synchronous level that changes only between clock edges. They also assume that FILTER_CYCLES, TRANSIENT_MIN and HOLDOFF_CYCLES are at least 1 and CLEAR_CYCLES is at least 2, so that a falling trip is always followed by at least one held cycle. The stimulus follows these assumptions by driving every input on the falling clock edge. It uses a reduced configuration (filter 4, clear 20, transient 3, hold-off 10). It sweeps every sub-threshold pulse length and every phase, so the windows can be counted cycle by cycle against the parameters.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  // bits needed to hold the values 0 .. limit-1
  function automatic int cnt_bits(input int limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction
endpackage

// File: rtl/bfs_level_filter.sv
module bfs_level_filter #(
  parameter int STABLE    = 44,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic qual_o
);
  localparam int CW = bfs_pkg::cnt_bits(STABLE);
  localparam logic [CW-1:0] LAST = CW'(STABLE - 1);

  logic [CW-1:0] run_cnt;
  logic          flip;

  // the qualified level follows raw only after STABLE differing samples
  assign flip = (raw_i != qual_o) && (run_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qual_o  <= RESET_VAL;
      run_cnt <= '0;
    end else if (raw_i == qual_o) begin
      run_cnt <= '0;
    end else if (flip) begin
      qual_o  <= raw_i;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // R2: a change of the qualified level always agrees with the raw input
  assert_filter_follows_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_o != $past(qual_o)) |-> (qual_o == $past(raw_i)));
endmodule

// File: rtl/bfs_trip_latch.sv
module bfs_trip_latch #(
  parameter int CLEAR = 206250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_q_i,
  output logic held_o
);
  localparam int CW = bfs_pkg::cnt_bits(CLEAR);
  localparam logic [CW-1:0] LAST = CW'(CLEAR - 1);

  logic          latched;
  logic [CW-1:0] clr_cnt;
  logic          expire;

  assign expire = latched && !trip_q_i && (clr_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latched <= 1'b1;
      clr_cnt <= '0;
    end else if (trip_q_i) begin
      latched <= 1'b1;
      clr_cnt <= '0;
    end else if (expire) begin
      latched <= 1'b0;
      clr_cnt <= '0;
    end else if (latched) begin
      clr_cnt <= clr_cnt + 1'b1;
    end
  end

  assign held_o = latched | trip_q_i;

  // R3: release only happens with the trip inactive on two samples
  assert_release_after_trip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latched) |-> (!trip_q_i && !$past(trip_q_i)));
  // R4: any qualified trip keeps the hold in force on the next cycle
  assert_trip_reloads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trip_q_i |=> held_o);
endmodule

// File: rtl/bfs_hs_guard.sv
module bfs_hs_guard #(
  parameter int TR_MIN = 13,
  parameter int HOLD   = 563
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_n_i,
  input  logic supply_uv_i,
  input  logic neg_tr_i,
  input  logic bridge_ok_i,
  output logic permit_o
);
  localparam int RW = bfs_pkg::cnt_bits(TR_MIN);
  localparam int HW = bfs_pkg::cnt_bits(HOLD + 1);
  localparam logic [RW-1:0] RUN_LAST  = RW'(TR_MIN - 1);
  localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD);

  logic          cmd_prev;
  logic          armed;
  logic [RW-1:0] tr_run;
  logic [HW-1:0] hold_cnt;
  logic          fresh_on;
  logic          tr_qual;
  logic          holding;

  assign fresh_on = cmd_prev & ~cmd_n_i;
  assign tr_qual  = neg_tr_i && (tr_run == RUN_LAST);
  assign holding  = (hold_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_prev <= 1'b1;
      armed    <= 1'b0;
      tr_run   <= '0;
      hold_cnt <= '0;
    end else begin
      cmd_prev <= cmd_n_i;
      if (supply_uv_i)   armed <= 1'b0;
      else if (fresh_on) armed <= 1'b1;
      if (!neg_tr_i)               tr_run <= '0;
      else if (tr_run != RUN_LAST) tr_run <= tr_run + 1'b1;
      if (tr_qual)      hold_cnt <= HOLD_LOAD;
      else if (holding) hold_cnt <= hold_cnt - 1'b1;
    end
  end

  assign permit_o = bridge_ok_i & armed & ~supply_uv_i & ~holding;

  // R7: a weak high-side supply never lets the high side drive
  assert_hs_uv_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    supply_uv_i |-> !permit_o);
  // R8: arming needs a low command sample with a good supply
  assert_arm_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> (!$past(cmd_n_i) && !$past(supply_uv_i)));
  // R9: a qualified transient blanks the high side on the next cycle
  assert_transient_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tr_qual |=> !permit_o);
endmodule

// File: rtl/bridge_fault_supervisor.sv
module bridge_fault_supervisor #(
  parameter int PHASES         = 3,
  parameter int FILTER_CYCLES  = 44,
  parameter int CLEAR_CYCLES   = 206250,
  parameter int TRANSIENT_MIN  = 13,
  parameter int HOLDOFF_CYCLES = 563
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trip_i,
  input  logic              enable_i,
  input  logic              logic_uv_i,
  input  logic [PHASES-1:0] hs_uv_i,
  input  logic [PHASES-1:0] neg_tr_i,
  input  logic [PHASES-1:0] hs_cmd_n_i,
  output logic              fault_n_o,
  output logic [PHASES-1:0] hs_permit_o,
  output logic [PHASES-1:0] ls_permit_o
);
  logic trip_q;
  logic enable_q;
  logic trip_held;
  logic bridge_ok;

  bfs_level_filter #(.STABLE(FILTER_CYCLES), .RESET_VAL(1'b0)) u_trip_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(trip_i), .qual_o(trip_q));

  bfs_level_filter #(.STABLE(FILTER_CYCLES), .RESET_VAL(1'b0)) u_en_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(enable_i), .qual_o(enable_q));

  bfs_trip_latch #(.CLEAR(CLEAR_CYCLES)) u_trip_latch (
    .clk(clk), .rst_n(rst_n), .trip_q_i(trip_q), .held_o(trip_held));

  assign bridge_ok   = enable_q & ~trip_held & ~logic_uv_i;
  assign fault_n_o   = ~(trip_held | logic_uv_i);
  assign ls_permit_o = {PHASES{bridge_ok}};

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    bfs_hs_guard #(.TR_MIN(TRANSIENT_MIN), .HOLD(HOLDOFF_CYCLES)) u_guard (
      .clk(clk), .rst_n(rst_n),
      .cmd_n_i(hs_cmd_n_i[p]), .supply_uv_i(hs_uv_i[p]), .neg_tr_i(neg_tr_i[p]),
      .bridge_ok_i(bridge_ok), .permit_o(hs_permit_o[p]));
  end

  // R1: a qualified trip reports a fault and stops all six switches
  assert_trip_shuts_bridge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    trip_q |-> (!fault_n_o && hs_permit_o == '0 && ls_permit_o == '0));
  // R5: logic undervoltage reports a fault and stops the low sides
  assert_logic_uv_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    logic_uv_i |-> (!fault_n_o && ls_permit_o == '0));
  // R6: a disabled bridge drives nothing
  assert_enable_silences_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_q |-> (hs_permit_o == '0 && ls_permit_o == '0));
  // R10: no high side without its low-side conditions being met
  assert_hs_implies_bridge_ok_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_permit_o != '0) |-> (ls_permit_o != '0 && fault_n_o));
endmodule

// File: tb/tb_bridge_fault_supervisor.sv
`timescale 1ns/1ps
module tb_bridge_fault_supervisor;
  localparam int NP   = 3;
  localparam int FILT = 4;
  localparam int CLR  = 20;
  localparam int TRM  = 3;
  localparam int HLD  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trip = 1'b0, en = 1'b1, luv = 1'b0;
  logic [NP-1:0] hsuv = '0, ntr = '0, hcmd = '1;
  logic fault_n;
  logic [NP-1:0] hs, ls;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  bridge_fault_supervisor #(.PHASES(NP), .FILTER_CYCLES(FILT), .CLEAR_CYCLES(CLR),
    .TRANSIENT_MIN(TRM), .HOLDOFF_CYCLES(HLD)) dut (
    .clk(clk), .rst_n(rst_n), .trip_i(trip), .enable_i(en), .logic_uv_i(luv),
    .hs_uv_i(hsuv), .neg_tr_i(ntr), .hs_cmd_n_i(hcmd),
    .fault_n_o(fault_n), .hs_permit_o(hs), .ls_permit_o(ls));

  // expected pattern {fault_n, hs, ls}
  function automatic logic [6:0] pat(input logic f, input logic [2:0] h, input logic [2:0] l);
    return {f, h, l};
  endfunction
  localparam logic [6:0] ALL_ON  = 7'h7F;
  localparam logic [6:0] ALL_OFF = 7'h00;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [6:0] exp);
    checks++;
    if ({fault_n, hs, ls} !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, {fault_n, hs, ls}, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    chk("R10 in reset", ALL_OFF);
    rst_n = 1'b1;
    tick(CLR - 1);
    chk("R10 held after reset", ALL_OFF);
    tick(1);
    chk("R10 release, high sides unarmed", pat(1'b1, 3'b000, 3'b111));
    hcmd = '0;
    tick(1);
    chk("R8 arming edge after reset", ALL_ON);

    // R1 / R3: trip held long, clear counted from qualified release
    trip = 1'b1;
    tick(FILT - 1);
    chk("R1 before qualification", ALL_ON);
    tick(1);
    chk("R1 trip qualified", ALL_OFF);
    tick(30);
    chk("R3 timer held during trip", ALL_OFF);
    trip = 1'b0;
    tick(FILT + CLR - 1);
    chk("R3 last held cycle", ALL_OFF);
    tick(1);
    chk("R3 released", ALL_ON);

    // R4: retrip while clear counter runs
    trip = 1'b1;
    tick(FILT + 2);
    trip = 1'b0;
    tick(FILT + 10);
    chk("R4 counter running", ALL_OFF);
    trip = 1'b1;
    tick(FILT);
    chk("R4 second trip", ALL_OFF);
    trip = 1'b0;
    tick(FILT + CLR - 1);
    chk("R4 full interval restarted", ALL_OFF);
    tick(1);
    chk("R4 released", ALL_ON);

    // R2: every sub-threshold pulse length on trip and enable
    for (int len = 1; len < FILT; len++) begin
      trip = 1'b1;
      for (int k = 0; k < len; k++) begin tick(1); chk("R2 trip pulse", ALL_ON); end
      trip = 1'b0;
      for (int k = 0; k < FILT + 2; k++) begin tick(1); chk("R2 trip after", ALL_ON); end
      en = 1'b0;
      for (int k = 0; k < len; k++) begin tick(1); chk("R2 enable pulse", ALL_ON); end
      en = 1'b1;
      for (int k = 0; k < FILT + 2; k++) begin tick(1); chk("R2 enable after", ALL_ON); end
    end

    // R6: enable low, no fault
    en = 1'b0;
    tick(FILT - 1);
    chk("R6 before qualification", ALL_ON);
    tick(1);
    chk("R6 disabled, fault high", pat(1'b1, 3'b000, 3'b000));
    tick(5);
    chk("R6 still disabled", pat(1'b1, 3'b000, 3'b000));
    en = 1'b1;
    tick(FILT);
    chk("R6 resumed", ALL_ON);

    // R5: logic undervoltage, not latched
    luv = 1'b1;
    tick(1);
    chk("R5 uv active", ALL_OFF);
    tick(5);
    chk("R5 uv held", ALL_OFF);
    luv = 1'b0;
    tick(1);
    chk("R5 uv released", ALL_ON);

    // R7 / R8 per phase
    for (int p = 0; p < NP; p++) begin
      logic [2:0] others;
      others = 3'b111 & ~(3'b001 << p);
      hsuv[p] = 1'b1;
      tick(1);
      chk("R7 one high side off", pat(1'b1, others, 3'b111));
      hcmd[p] = 1'b1;
      tick(2);
      hcmd[p] = 1'b0;
      tick(2);
      chk("R8 edge during uv ignored", pat(1'b1, others, 3'b111));
      hsuv[p] = 1'b0;
      tick(3);
      chk("R8 waits for edge", pat(1'b1, others, 3'b111));
      hcmd[p] = 1'b1;
      tick(2);
      chk("R8 command high, no edge yet", pat(1'b1, others, 3'b111));
      hcmd[p] = 1'b0;
      tick(1);
      chk("R8 rearmed", ALL_ON);
    end

    // R9 per phase
    for (int p = 0; p < NP; p++) begin
      logic [2:0] others;
      others = 3'b111 & ~(3'b001 << p);
      ntr[p] = 1'b1;
      for (int k = 0; k < TRM - 1; k++) begin tick(1); chk("R9 short transient", ALL_ON); end
      ntr[p] = 1'b0;
      for (int k = 0; k < HLD + 2; k++) begin tick(1); chk("R9 short ignored", ALL_ON); end
      ntr[p] = 1'b1;
      tick(TRM - 1);
      chk("R9 before qualification", ALL_ON);
      tick(1);
      chk("R9 hold-off active", pat(1'b1, others, 3'b111));
      ntr[p] = 1'b0;
      tick(HLD - 1);
      chk("R9 hold-off last cycle", pat(1'b1, others, 3'b111));
      tick(1);
      chk("R9 hold-off over", ALL_ON);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule